// File: doc/BRIEF.md
# Reloadable Watchdog and Alarm Down-Counter

This block is a 24-bit down-counter with two personalities. In periodic mode it counts down once per slow tick (1 Hz), and on reaching zero it loads the programmed value again and keeps running, so it raises an alarm at a fixed interval. In watchdog mode it counts down on the fast tick (4096 Hz), and on reaching zero it raises the alarm and stops. Either way, touching one of the counter bytes through the register port, or a rising edge on the kick input, restarts the count from the programmed value before it can expire.

The programmed value lives in its own register, separate from the live count, so a halted watchdog can be re-armed without being written again. When the run-enable bit is clear the counter stays frozen, and its three bytes act as plain read/write storage. An oscillator-stop bit freezes all counting. The alarm flag is sticky. Only software can clear it, by writing 0 to it.

Top module: `reload_countdown`

## Requirements
- R1: Addresses 0, 1 and 2 hold bits 7:0, 15:8 and 23:16 of the 24-bit reload value. A write stores its byte there, and a read returns the stored byte.
- R2: While the run-enable bit (address 3, bit 0) is 0, the live count never changes on ticks, and the three counter bytes still store and return written data.
- R3: With the mode bit (address 3, bit 1) at 0, each slow tick lowers the live count by one. A slow tick taken at a count of 1 or 0 loads the reload value, sets the alarm flag, and counting carries on.
- R4: With the mode bit at 1, each fast tick lowers the live count by one. A fast tick taken at a count of 1 or 0 sets the alarm flag, leaves the count at 0, and stops counting until the next restart.
- R5: A read or a write at addresses 0 to 2 restarts the counter. On the next clock edge the live count takes the reload value, including any byte written in that same cycle, and counting resumes. A restart takes precedence over a tick in the same cycle.
- R6: A rising edge on kick_i restarts the counter. The live count is reloaded on the third clock edge after kick_i goes high. Holding kick_i high causes no further restarts.
- R7: The alarm flag is address 4, bit 0, and also appears on alarm_o. It sets on every expiry. A write to address 4 with bit 0 at 0 clears it, and a write with bit 0 at 1 does nothing. A restart leaves it alone. If an expiry and a clear fall in the same cycle, the set wins.
- R8: While the oscillator-stop bit (address 3, bit 7) is 1, ticks do not change the live count and cause no expiry.
- R9: After reset the reload value, the live count, all control bits and the alarm flag are 0.
- R10: A tick of the rate not selected by the mode bit has no effect on the count or the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_slow_i | input | 1 | One-cycle strobe at the slow (1 Hz) rate |
| tick_fast_i | input | 1 | One-cycle strobe at the fast (4096 Hz) rate |
| kick_i | input | 1 | Asynchronous watchdog kick; a rising edge restarts the count |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| count_o | output | 24 | Live count |
| alarm_o | output | 1 | Sticky alarm flag |

## Verification
The bench targets the expiry boundary in each mode. A design that decrements past zero would wrap to all ones. One that halts in periodic mode, or keeps running in watchdog mode, would leave the live count wrong on the next tick. Restarts are checked when they collide with a tick and when they coincide with a byte write. A design that lets the tick win, or that loads the stale reload value, shows a one-off count. The kick path is driven with a long high pulse, which catches a level-sensitive detector that restarts on every cycle. Flag clears are issued both alone and together with an expiry, which catches a clear that wrongly takes priority.

// File: rtl/reload_pkg.sv
package reload_pkg;
  localparam int BYTE_W        = 8;
  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_MODE_BIT = 1;
  localparam int CTRL_STOP_BIT = 7;
  localparam int STAT_FLAG_BIT = 0;

  typedef struct packed {
    logic osc_stop;
    logic fast_mode;
    logic run_en;
  } ctrl_t;
endpackage

// File: rtl/kick_sync.sv
module kick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kick_i,
  output logic pulse_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], kick_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign pulse_o = sync_q[STAGES-1] & ~last_q;

  // R6: a held level yields one pulse only
  a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/ctrl_regs.sv
module ctrl_regs
  import reload_pkg::*;
#(
  parameter int BYTES = 3,
  parameter int AW    = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic                  rd_en_i,
  input  logic [AW-1:0]         addr_i,
  input  logic [BYTE_W-1:0]     wdata_i,
  input  logic                  expire_i,
  output logic [BYTES*BYTE_W-1:0] reload_next_o,
  output ctrl_t                 ctrl_o,
  output logic                  alarm_o,
  output logic                  access_o,
  output logic [BYTE_W-1:0]     rdata_o
);
  localparam int          W         = BYTES * BYTE_W;
  localparam logic [AW-1:0] CTRL_ADDR = AW'(BYTES);
  localparam logic [AW-1:0] STAT_ADDR = AW'(BYTES + 1);

  logic [W-1:0] reload_q;
  ctrl_t        ctrl_q;
  logic         alarm_q;
  logic         clr_req;

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    assign reload_next_o[b*BYTE_W +: BYTE_W] =
      (wr_en_i && addr_i == AW'(b)) ? wdata_i : reload_q[b*BYTE_W +: BYTE_W];
  end

  assign access_o = (wr_en_i | rd_en_i) && (addr_i < AW'(BYTES));
  assign clr_req  = wr_en_i && addr_i == STAT_ADDR && !wdata_i[STAT_FLAG_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q <= '0;
      ctrl_q   <= '0;
      alarm_q  <= 1'b0;
    end else begin
      reload_q <= reload_next_o;
      if (wr_en_i && addr_i == CTRL_ADDR) begin
        ctrl_q.run_en    <= wdata_i[CTRL_EN_BIT];
        ctrl_q.fast_mode <= wdata_i[CTRL_MODE_BIT];
        ctrl_q.osc_stop  <= wdata_i[CTRL_STOP_BIT];
      end
      if (expire_i)     alarm_q <= 1'b1;  // set beats clear
      else if (clr_req) alarm_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int b = 0; b < BYTES; b++)
      if (addr_i == AW'(b)) rdata_o = reload_q[b*BYTE_W +: BYTE_W];
    if (addr_i == CTRL_ADDR) begin
      rdata_o[CTRL_EN_BIT]   = ctrl_q.run_en;
      rdata_o[CTRL_MODE_BIT] = ctrl_q.fast_mode;
      rdata_o[CTRL_STOP_BIT] = ctrl_q.osc_stop;
    end
    if (addr_i == STAT_ADDR) rdata_o[STAT_FLAG_BIT] = alarm_q;
  end

  assign ctrl_o  = ctrl_q;
  assign alarm_o = alarm_q;

  a_r7_flag_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> alarm_q);
  a_r7_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_q && !clr_req) |=> alarm_q);
  a_r1_byte_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(reload_q));
endmodule

// File: rtl/count_core.sv
module count_core #(
  parameter int W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_en_i,
  input  logic         fast_i,
  input  logic         stop_i,
  input  logic         tick_slow_i,
  input  logic         tick_fast_i,
  input  logic         restart_i,
  input  logic [W-1:0] reload_i,
  output logic [W-1:0] cnt_o,
  output logic         expire_o
);
  logic [W-1:0] cnt_q;
  logic         run_q;
  logic         tick;
  logic         active;
  logic         at_end;

  assign tick     = fast_i ? tick_fast_i : tick_slow_i;
  assign active   = run_en_i & ~stop_i & run_q;
  assign at_end   = cnt_q <= W'(1);
  assign expire_o = active & tick & ~restart_i & at_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b1;
    end else if (restart_i) begin
      cnt_q <= reload_i;
      run_q <= 1'b1;
    end else if (active && tick) begin
      if (at_end) begin
        if (fast_i) begin
          cnt_q <= '0;
          run_q <= 1'b0;
        end else begin
          cnt_q <= reload_i;
        end
      end else begin
        cnt_q <= cnt_q - W'(1);
      end
    end
  end

  assign cnt_o = cnt_q;

  a_r4_fast_halts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && fast_i) |=> (cnt_q == '0 && !run_q));
  a_r3_slow_reloads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && !fast_i) |=> cnt_q == $past(reload_i));
  a_r5_restart_runs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> run_q);
  a_r2_disabled_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_en_i && !restart_i) |=> $stable(cnt_q));
  a_r8_stop_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !restart_i) |=> $stable(cnt_q));
endmodule

// File: rtl/reload_countdown.sv
module reload_countdown
  import reload_pkg::*;
#(
  parameter int BYTES       = 3,
  parameter int AW          = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    tick_slow_i,
  input  logic                    tick_fast_i,
  input  logic                    kick_i,
  input  logic                    wr_en_i,
  input  logic                    rd_en_i,
  input  logic [AW-1:0]           addr_i,
  input  logic [7:0]              wdata_i,
  output logic [7:0]              rdata_o,
  output logic [BYTES*8-1:0]      count_o,
  output logic                    alarm_o
);
  localparam int W = BYTES * BYTE_W;

  logic         kick_pulse;
  logic         access;
  logic         expire;
  logic [W-1:0] reload_next;
  ctrl_t        ctrl;

  kick_sync #(.STAGES(SYNC_STAGES)) u_kick (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .kick_i  (kick_i),
    .pulse_o (kick_pulse)
  );

  ctrl_regs #(.BYTES(BYTES), .AW(AW)) u_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_en_i       (wr_en_i),
    .rd_en_i       (rd_en_i),
    .addr_i        (addr_i),
    .wdata_i       (wdata_i),
    .expire_i      (expire),
    .reload_next_o (reload_next),
    .ctrl_o        (ctrl),
    .alarm_o       (alarm_o),
    .access_o      (access),
    .rdata_o       (rdata_o)
  );

  count_core #(.W(W)) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_en_i    (ctrl.run_en),
    .fast_i      (ctrl.fast_mode),
    .stop_i      (ctrl.osc_stop),
    .tick_slow_i (tick_slow_i),
    .tick_fast_i (tick_fast_i),
    .restart_i   (access | kick_pulse),
    .reload_i    (reload_next),
    .cnt_o       (count_o),
    .expire_o    (expire)
  );
endmodule

// File: tb/sim_reload_countdown.sv
`timescale 1ns/1ps
module sim_reload_countdown;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ts = 0, tf = 0, kick = 0, wr = 0, rd = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic [23:0] cnt;
  logic alarm;
  int n_chk = 0, n_fail = 0;
  string phase = "R9";

  always #2.5 clk = ~clk;

  reload_countdown u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_slow_i(ts), .tick_fast_i(tf),
    .kick_i(kick), .wr_en_i(wr), .rd_en_i(rd), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .count_o(cnt), .alarm_o(alarm));

  // behavioural reference
  int m_rel, m_cnt, m_run, m_en, m_fast, m_stop, m_alarm, k1, k2, kl;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rel = 0; m_cnt = 0; m_run = 1; m_en = 0; m_fast = 0; m_stop = 0;
      m_alarm = 0; k1 = 0; k2 = 0; kl = 0;
    end else begin
      int nrel, edge_k, rs, tk, act, exp_now;
      nrel = m_rel;
      if (wr && addr < 3) begin
        nrel = nrel & ~(32'hFF << (8*addr));
        nrel = nrel | (int'(wdata) << (8*addr));
      end
      edge_k = (k2 && !kl);
      rs = ((wr || rd) && addr < 3) || edge_k;
      tk = m_fast ? tf : ts;
      act = m_en && !m_stop && m_run;
      exp_now = act && tk && !rs && (m_cnt <= 1);
      if (rs) begin m_cnt = nrel; m_run = 1; end
      else if (act && tk) begin
        if (m_cnt <= 1) begin
          if (m_fast) begin m_cnt = 0; m_run = 0; end
          else m_cnt = nrel;
        end else m_cnt = m_cnt - 1;
      end
      if (wr && addr == 3) begin
        m_en = wdata[0]; m_fast = wdata[1]; m_stop = wdata[7];
      end
      if (exp_now) m_alarm = 1;
      else if (wr && addr == 4 && !wdata[0]) m_alarm = 0;
      m_rel = nrel;
      kl = k2; k2 = k1; k1 = kick;
    end
  end

  function automatic int model_rdata(int a);
    case (a)
      0, 1, 2: return (m_rel >> (8*a)) & 8'hFF;
      3:       return m_en | (m_fast << 1) | (m_stop << 7);
      4:       return m_alarm;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string req, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(phase, int'(cnt), m_cnt, "count");
    chk(phase, int'(alarm), m_alarm, "alarm");
    chk(phase, int'(rdata), model_rdata(int'(addr)), "rdata");
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wreg(int a, int d);
    @(negedge clk); #1; wr = 1; addr = 3'(a); wdata = 8'(d);
    @(negedge clk); #1; wr = 0;
  endtask
  task automatic rreg(int a);
    @(negedge clk); #1; rd = 1; addr = 3'(a);
    @(negedge clk); #1; rd = 0;
  endtask
  task automatic tick(bit fast);
    @(negedge clk); #1; if (fast) tf = 1; else ts = 1;
    @(negedge clk); #1; tf = 0; ts = 0;
  endtask

  initial begin
    #500000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    phase = "R9";
    chk("R9", int'(cnt), 0, "reset count");
    chk("R9", int'(alarm), 0, "reset alarm");
    // R1: bytes store and read back
    phase = "R1";
    wreg(0, 8'h5A); wreg(1, 8'hC3); wreg(2, 8'h81);
    for (int a = 0; a < 5; a++) begin @(negedge clk); #1 addr = 3'(a); end
    #1 addr = 1; @(negedge clk); chk("R1", int'(rdata), 8'hC3, "byte1 readback");
    // R2: disabled - ticks frozen, storage works
    phase = "R2";
    tick(0); tick(1); tick(0);
    @(negedge clk); chk("R2", int'(cnt), 24'h81C35A, "disabled count");
    wreg(2, 8'h00); wreg(1, 8'h00); wreg(0, 8'h03);
    // R3: periodic mode, reload 3
    phase = "R3";
    wreg(3, 8'h01);
    for (int i = 0; i < 8; i++) begin tick(0); idle(1); end
    // R10: fast ticks ignored in slow mode
    phase = "R10";
    for (int i = 0; i < 5; i++) tick(1);
    // R7: clear, write-1 ignored, clear racing expiry
    phase = "R7";
    wreg(4, 8'h01);
    @(negedge clk); chk("R7", int'(alarm), 1, "write 1 keeps flag");
    wreg(4, 8'h00);
    @(negedge clk); chk("R7", int'(alarm), 0, "write 0 clears flag");
    rreg(0); tick(0); tick(0); // count at 1
    @(negedge clk); #1 wr = 1; addr = 4; wdata = 0; ts = 1;
    @(negedge clk); #1 wr = 0; ts = 0;
    @(negedge clk); chk("R7", int'(alarm), 1, "set beats clear");
    rreg(1);
    @(negedge clk); chk("R7", int'(alarm), 1, "restart keeps flag");
    wreg(4, 8'h00);
    // R4: watchdog mode, reload 2
    phase = "R4";
    wreg(0, 8'h02); wreg(3, 8'h03);
    for (int i = 0; i < 5; i++) tick(1);
    @(negedge clk); chk("R4", int'(cnt), 0, "halted at zero");
    chk("R4", int'(alarm), 1, "watchdog flag");
    tick(0);
    // R5: restart via read, restart vs tick, write merge
    phase = "R5";
    wreg(4, 8'h00);
    rreg(2);
    @(negedge clk); chk("R5", int'(cnt), 2, "read restarts");
    tick(1);
    @(negedge clk); #1 rd = 1; addr = 0; tf = 1;
    @(negedge clk); #1 rd = 0; tf = 0;
    @(negedge clk); chk("R5", int'(cnt), 2, "restart beats tick");
    wreg(1, 8'h01);
    @(negedge clk); chk("R5", int'(cnt), 24'h000102, "write merges into restart");
    // R6: kick held high restarts once
    phase = "R6";
    for (int i = 0; i < 4; i++) tick(1);
    @(negedge clk); #1 kick = 1;
    idle(4);
    for (int i = 0; i < 3; i++) tick(1);
    @(negedge clk); chk("R6", int'(cnt), 24'h0000FF, "held kick no retrigger");
    #1 kick = 0;
    idle(3);
    // R8: oscillator stop freezes counting
    phase = "R8";
    wreg(3, 8'h83);
    for (int i = 0; i < 4; i++) tick(1);
    @(negedge clk); chk("R8", int'(cnt), 24'h0000FF, "stopped count");
    wreg(3, 8'h03); tick(1);
    // R2 again: disable mid count
    phase = "R2";
    wreg(3, 8'h00); tick(0); tick(1);
    idle(2);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule